// File: doc/BRIEF.md
# Byte-Order-Selectable Unaligned Load/Store Unit

This unit sits between a processor's load/store stage and a data memory organised as 32-bit words with per-byte write enables. The processor can issue a load or a store of 1, 2, 4, 8, 12 or 16 bytes at any byte address. The unit breaks the access into aligned word transactions and steers each byte to or from its lane. For loads, it collects the returned words into one right-justified value.

A byte-order input, sampled with each request, chooses how the bytes of a multi-byte value map onto ascending addresses. A second input turns misaligned accesses into a fault instead of a split access. Requests use a valid/ready handshake and are handled one at a time. The memory port is synchronous: read data appears one cycle after the request.

Top module: `lsu_align`

## Requirements
- R1: `req_ready` is high only when no request is in progress. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low until that request has finished.
- R2: `req_size` encodes the item length as 0=1, 1=2, 2=4, 3=8, 4=12 and 5=16 bytes. Any byte address is accepted.
- R3: An item of N bytes at address A is issued as ceil(((A mod 4)+N)/4) memory transactions. They run on consecutive cycles at ascending word addresses, starting with word A/4. Lane j of a word W (`mem_wdata`/`mem_rdata` bits 8j+7..8j, `mem_be` bit j) holds byte address 4W+j.
- R4: A store enables exactly the lanes that hold bytes of the item. All other memory bytes keep their values.
- R5: When `big_endian`=0, byte A+i holds bits 8i+7..8i of the value, for both loads and stores.
- R6: When `big_endian`=1, byte A+i holds bits 8(N-1-i)+7..8(N-1-i) of the value, for both loads and stores. Bit numbering inside a byte is the same in both byte orders.
- R7: A load gives exactly one `rsp_valid` pulse, two cycles after its last transaction. `rsp_rdata` holds the value right-justified, with every byte above N equal to zero. A store gives no pulse.
- R8: With `fault_en`=1, a misaligned request still completes its handshake. It raises `fault` for the single following cycle, makes no memory transaction and gives no response. A request is misaligned when A is not a multiple of N; a 12-byte item is checked against a 16-byte boundary.
- R9: With `fault_en`=0, a misaligned request is carried out as a split access and raises no fault.
- R10: With `fault_en`=1, an aligned request is carried out normally and raises no fault.
- R11: After reset, `req_ready` is high and `mem_en`, `rsp_valid` and `fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| big_endian | input | 1 | Byte order for the request being accepted |
| fault_en | input | 1 | Fault on misaligned requests instead of performing them |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 3 | Item length code |
| req_addr | input | AW | Byte address |
| req_wdata | input | 128 | Store value, right-justified |
| mem_en | output | 1 | Memory transaction this cycle |
| mem_we | output | 1 | Transaction is a write |
| mem_addr | output | AW-2 | Word address |
| mem_be | output | 4 | Lane enables |
| mem_wdata | output | 32 | Write word |
| mem_rdata | input | 32 | Read word, one cycle after the transaction |
| rsp_valid | output | 1 | Load result pulse |
| rsp_rdata | output | 128 | Load value, right-justified, zero-filled |
| fault | output | 1 | Alignment fault pulse |

## Verification
Some properties are checked on every cycle. A transaction never occurs while the unit reports idle. Back-to-back transactions step the word address by one, and every transaction enables at least one lane. A fault pulse always follows an accepted request and never coincides with a memory access or a response. A response is a single-cycle pulse that never overlaps a transaction. Byte placement, lane enables, the transaction count and the value returned for each byte order can only be shown by the bench. It stores and reloads items against its own byte-level model of memory, reloads them in the opposite byte order, and runs directed cases for the fault rules and the 12-byte alignment rule.

// File: rtl/lsu_align.sv
module lsu_align #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          big_endian,
  input  logic          fault_en,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [2:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [127:0]  req_wdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-3:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          rsp_valid,
  output logic [127:0]  rsp_rdata,
  output logic          fault
);
  localparam int WINW = 160;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_CAPT, S_RESP} st_t;

  function automatic logic [127:0] keep_bytes(input logic [127:0] v, input logic [4:0] n);
    logic [127:0] r;
    for (int i = 0; i < 16; i++)
      r[8*i +: 8] = (i < int'(n)) ? v[8*i +: 8] : 8'h00;
    return r;
  endfunction

  function automatic logic [127:0] swap_bytes(input logic [127:0] v, input logic [4:0] n);
    logic [127:0] r;
    int j;
    for (int i = 0; i < 16; i++) begin
      j = int'(n) - 1 - i;
      r[8*i +: 8] = (i < int'(n)) ? v[8*j +: 8] : 8'h00;
    end
    return r;
  endfunction

  st_t            st;
  logic [2:0]     cnt, nw_q, rd_idx;
  logic [AW-3:0]  waddr;
  logic           wr_q, be_mode_q, rd_pend, fault_q;
  logic [WINW-1:0] win;
  logic [19:0]    be_q;
  logic [1:0]     off_q;
  logic [4:0]     nb_q;

  logic [4:0]     nb;
  logic [3:0]     amask;
  logic [15:0]    imask;
  logic [127:0]   st_img, ld_m;
  logic [4:0]     span;

  always_comb begin
    case (req_size)
      3'd0:    begin nb = 5'd1;  amask = 4'h0; end
      3'd1:    begin nb = 5'd2;  amask = 4'h1; end
      3'd2:    begin nb = 5'd4;  amask = 4'h3; end
      3'd3:    begin nb = 5'd8;  amask = 4'h7; end
      3'd4:    begin nb = 5'd12; amask = 4'hF; end
      default: begin nb = 5'd16; amask = 4'hF; end
    endcase
  end

  wire accept     = req_valid && req_ready;
  wire misaligned = |(req_addr[3:0] & amask);
  wire fault_take = accept && fault_en && misaligned;

  assign imask  = (nb == 5'd16) ? 16'hFFFF : ((16'h1 << nb) - 16'h1);
  assign st_img = big_endian ? swap_bytes(req_wdata, nb) : keep_bytes(req_wdata, nb);
  assign span   = {3'b000, req_addr[1:0]} + nb + 5'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      nw_q      <= '0;
      waddr     <= '0;
      wr_q      <= 1'b0;
      be_mode_q <= 1'b0;
      win       <= '0;
      be_q      <= '0;
      off_q     <= '0;
      nb_q      <= '0;
      rd_pend   <= 1'b0;
      rd_idx    <= '0;
      fault_q   <= 1'b0;
    end else begin
      fault_q <= fault_take;
      rd_pend <= mem_en && !wr_q;
      rd_idx  <= cnt;
      case (st)
        S_IDLE: if (accept && !fault_take) begin
          st        <= S_ISSUE;
          cnt       <= '0;
          nw_q      <= span[4:2];
          waddr     <= req_addr[AW-1:2];
          wr_q      <= req_write;
          be_mode_q <= big_endian;
          win       <= req_write ? ({32'b0, st_img} << {req_addr[1:0], 3'b000}) : '0;
          be_q      <= {4'b0, imask} << req_addr[1:0];
          off_q     <= req_addr[1:0];
          nb_q      <= nb;
        end
        S_ISSUE: begin
          cnt <= cnt + 3'd1;
          if (cnt == nw_q - 3'd1) st <= wr_q ? S_IDLE : S_CAPT;
        end
        S_CAPT:  st <= S_RESP;
        default: st <= S_IDLE;
      endcase
      if (rd_pend) win[32*rd_idx +: 32] <= mem_rdata;
    end
  end

  assign req_ready = (st == S_IDLE);
  assign mem_en    = (st == S_ISSUE);
  assign mem_we    = mem_en && wr_q;
  assign mem_addr  = waddr + {{(AW-5){1'b0}}, cnt};
  assign mem_be    = mem_en ? be_q[4*cnt +: 4] : 4'h0;
  assign mem_wdata = win[32*cnt +: 32];

  assign ld_m      = 128'(win >> {off_q, 3'b000});
  assign rsp_valid = (st == S_RESP);
  assign rsp_rdata = be_mode_q ? swap_bytes(ld_m, nb_q) : keep_bytes(ld_m, nb_q);
  assign fault     = fault_q;
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          mem_en,
  input logic [AW-3:0] mem_addr,
  input logic [3:0]    mem_be,
  input logic          rsp_valid,
  input logic          fault
);
  assert_no_access_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> !req_ready);

  assert_addr_ascends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  assert_lane_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_be != 4'h0));

  assert_rsp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_rsp_no_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_en);

  assert_fault_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(req_valid && req_ready));

  assert_fault_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!mem_en && !rsp_valid));

  assert_fault_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);
endmodule

bind lsu_align lsu_align_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_en(mem_en), .mem_addr(mem_addr), .mem_be(mem_be),
  .rsp_valid(rsp_valid), .fault(fault)
);

// File: tb/test_lsu_align.sv
`timescale 1ns/1ps
module test_lsu_align;
  logic clk = 1'b0, rst_n = 1'b0;
  logic big_endian = 1'b0, fault_en = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic req_ready;
  logic [2:0] req_size = '0;
  logic [31:0] req_addr = '0;
  logic [127:0] req_wdata = '0;
  logic mem_en, mem_we, rsp_valid, fault;
  logic [29:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, mem_rdata;
  logic [127:0] rsp_rdata;

  always #2 clk = ~clk;

  lsu_align i_lsu_align (.*);

  logic [7:0] mb [0:255];
  logic [7:0] rf [0:255];
  int txn = 0;
  int n_cmp = 0, n_bad = 0;

  always @(posedge clk) begin
    if (mem_en) begin
      txn <= txn + 1;
      if (mem_we)
        for (int j = 0; j < 4; j++)
          if (mem_be[j]) mb[{mem_addr[5:0], 2'(j)}] <= mem_wdata[8*j +: 8];
      mem_rdata <= {mb[{mem_addr[5:0], 2'd3}], mb[{mem_addr[5:0], 2'd2}],
                    mb[{mem_addr[5:0], 2'd1}], mb[{mem_addr[5:0], 2'd0}]};
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [2:0] s);
    case (s)
      3'd0: return 1;  3'd1: return 2;  3'd2: return 4;
      3'd3: return 8;  3'd4: return 12; default: return 16;
    endcase
  endfunction

  function automatic int mem_diffs();
    int d = 0;
    for (int i = 0; i < 256; i++) if (mb[i] !== rf[i]) d++;
    return d;
  endfunction

  function automatic logic [127:0] ref_load(input bit be, input logic [2:0] s, input int a);
    logic [127:0] r = '0;
    int n = nbytes(s);
    for (int i = 0; i < n; i++)
      r[8*i +: 8] = be ? rf[a+n-1-i] : rf[a+i];
    return r;
  endfunction

  task automatic ref_store(input bit be, input logic [2:0] s, input int a, input logic [127:0] d);
    int n = nbytes(s);
    for (int i = 0; i < n; i++)
      rf[a+i] = be ? d[8*(n-1-i) +: 8] : d[8*i +: 8];
  endtask

  task automatic do_req(input bit w, input bit be, input logic [2:0] s, input int a,
                        input logic [127:0] d, output logic [127:0] q, output bit flt,
                        output int nt, output bit rsp_ok, output bit busy_ok);
    int guard;
    @(negedge clk);
    txn = 0;
    req_valid = 1'b1; req_write = w; big_endian = be; req_size = s;
    req_addr = 32'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    flt = fault;
    busy_ok = !req_ready;
    q = '0;
    rsp_ok = 1'b1;
    if (flt) begin
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (rsp_valid || mem_en) rsp_ok = 1'b0;
      end
    end else if (w) begin
      guard = 0;
      while (!req_ready && guard < 40) begin
        if (rsp_valid) rsp_ok = 1'b0;
        @(negedge clk); guard++;
      end
      @(negedge clk);
      if (rsp_valid) rsp_ok = 1'b0;
    end else begin
      guard = 0;
      while (!rsp_valid && guard < 40) begin @(negedge clk); guard++; end
      q = rsp_rdata;
      if (!rsp_valid) rsp_ok = 1'b0;
      @(negedge clk);
      if (rsp_valid) rsp_ok = 1'b0;
    end
    nt = txn;
  endtask

  // {big_endian, size code, byte address}
  localparam logic [11:0] VEC [0:15] = '{
    {1'b0, 3'd0, 8'h03}, {1'b0, 3'd1, 8'h05}, {1'b0, 3'd1, 8'h06}, {1'b0, 3'd2, 8'h07},
    {1'b0, 3'd2, 8'h08}, {1'b0, 3'd3, 8'h0D}, {1'b0, 3'd4, 8'h22}, {1'b0, 3'd5, 8'h31},
    {1'b1, 3'd0, 8'h40}, {1'b1, 3'd1, 8'h43}, {1'b1, 3'd2, 8'h4A}, {1'b1, 3'd2, 8'h50},
    {1'b1, 3'd3, 8'h5B}, {1'b1, 3'd4, 8'h61}, {1'b1, 3'd5, 8'h73}, {1'b1, 3'd5, 8'h80}
  };

  bit finished = 1'b0;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [127:0] q, d, exp;
    bit flt, rok, bok;
    int nt, a, n, ew;
    logic [2:0] s;
    bit be;

    for (int i = 0; i < 256; i++) begin
      mb[i] = 8'(i * 37 + 11);
      rf[i] = 8'(i * 37 + 11);
    end
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(req_ready === 1'b1 && mem_en === 1'b0 && rsp_valid === 1'b0 && fault === 1'b0,
        "R11", "reset outputs", {req_ready, mem_en, rsp_valid, fault}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R11", "ready after reset", req_ready, 1);

    foreach (VEC[v]) begin
      be = VEC[v][11];
      s  = VEC[v][10:8];
      a  = int'(VEC[v][7:0]);
      n  = nbytes(s);
      ew = ((a % 4) + n + 3) / 4;
      d  = '0;
      for (int k = 0; k < n; k++) d[8*k +: 8] = 8'((v * 16 + k + 1) ^ 8'h5A);
      // R2 R4 R5 R6 R9: store at any address, only item bytes change
      do_req(1'b1, be, s, a, d, q, flt, nt, rok, bok);
      ref_store(be, s, a, d);
      chk(!flt, "R9", "no fault when disabled", flt, 0);
      chk(bok, "R1", "ready low while busy", !bok, 0);
      chk(nt == ew, "R3", "store transaction count", nt, ew);
      chk(rok, "R7", "no response to store", !rok, 0);
      chk(mem_diffs() == 0, be ? "R6" : "R5", "memory bytes after store", mem_diffs(), 0);
      // R5 R6 R7: load back in same order
      do_req(1'b0, be, s, a, '0, q, flt, nt, rok, bok);
      chk(q === d, be ? "R6" : "R5", "load same order", q, d);
      chk(nt == ew, "R3", "load transaction count", nt, ew);
      chk(rok, "R7", "single response pulse", !rok, 0);
      // R5 R6: load in opposite order reverses the bytes
      exp = ref_load(!be, s, a);
      do_req(1'b0, !be, s, a, '0, q, flt, nt, rok, bok);
      chk(q === exp, "R6", "load opposite order", q, exp);
    end

    // R7: response timing, two cycles after last transaction (1-word load at 0x20)
    begin
      int last_t, rsp_t, cyc;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; big_endian = 1'b0; req_size = 3'd2; req_addr = 32'h20;
      @(negedge clk);
      req_valid = 1'b0;
      last_t = -1; rsp_t = -1;
      for (cyc = 0; cyc < 8; cyc++) begin
        if (mem_en) last_t = cyc;
        if (rsp_valid && rsp_t < 0) rsp_t = cyc;
        @(negedge clk);
      end
      chk(rsp_t - last_t == 2, "R7", "response delay after last word", rsp_t - last_t, 2);
    end

    fault_en = 1'b1;
    // R8: misaligned 4-byte store faults, memory untouched
    do_req(1'b1, 1'b0, 3'd2, 8'h91, 128'hDEADBEEF, q, flt, nt, rok, bok);
    chk(flt, "R8", "fault on misaligned store", flt, 1);
    chk(nt == 0, "R8", "no transactions on fault", nt, 0);
    chk(mem_diffs() == 0, "R8", "memory unchanged on fault", mem_diffs(), 0);
    chk(req_ready === 1'b1 && fault === 1'b0, "R8", "fault is one cycle", fault, 0);
    // R8: misaligned load faults with no response
    do_req(1'b0, 1'b1, 3'd1, 8'h95, '0, q, flt, nt, rok, bok);
    chk(flt && rok && nt == 0, "R8", "misaligned load fault, no response", {flt, rok, nt[3:0]}, 6'b110000);
    // R8: 12-byte item on 4-byte boundary but not 16-byte faults
    do_req(1'b0, 1'b0, 3'd4, 8'hA4, '0, q, flt, nt, rok, bok);
    chk(flt, "R8", "12-byte needs 16-byte boundary", flt, 1);
    // R10: aligned 12-byte store works with faults enabled
    d = 128'h0000_0000_A1B2C3D4_E5F60718_293A4B5C;
    do_req(1'b1, 1'b1, 3'd4, 8'hB0, d, q, flt, nt, rok, bok);
    ref_store(1'b1, 3'd4, 8'hB0, d);
    chk(!flt && nt == 3, "R10", "aligned 12-byte store", {flt, nt[3:0]}, 5'b00011);
    chk(mem_diffs() == 0, "R10", "memory after aligned store", mem_diffs(), 0);
    // R10: aligned 8-byte load works with faults enabled
    exp = ref_load(1'b0, 3'd3, 8'hC8);
    do_req(1'b0, 1'b0, 3'd3, 8'hC8, '0, q, flt, nt, rok, bok);
    chk(!flt && q === exp, "R10", "aligned 8-byte load", q, exp);
    // R2: 16-byte aligned load, full width, no fault
    exp = ref_load(1'b1, 3'd5, 8'hE0);
    do_req(1'b0, 1'b1, 3'd5, 8'hE0, '0, q, flt, nt, rok, bok);
    chk(!flt && q === exp && nt == 4, "R2", "aligned 16-byte load", q, exp);
    // R4 R6: single byte store leaves neighbours, bit 0 stays bit 0
    do_req(1'b1, 1'b1, 3'd0, 8'hF7, 128'h01, q, flt, nt, rok, bok);
    ref_store(1'b1, 3'd0, 8'hF7, 128'h01);
    chk(mb[8'hF7] === 8'h01 && mem_diffs() == 0, "R4", "single byte store", mb[8'hF7], 8'h01);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule